// File: doc/BRIEF.md
# Serial Printer Handshake Controller

This block sits between the parallel side of a UART and the handshake lines of a serial printer or similar peripheral. It does not frame any serial data. Its job is to decide when the transmit path may hand over another byte, to advertise its own state on the outgoing lines, and to flag transmit-time faults reported by the peripheral.

A host-driven enable gates the receive direction. A data-set-ready line rises once the block leaves reset. A ready line either stays up permanently or follows transmit activity, depending on a static configuration input. The peripheral's equipment-ready line starts and stops transmission. After that line drops, a small fixed number of further bytes is still allowed, because the serializer may already be committed to them. Two checks run while a byte is on the wire: one on the peripheral's ready line (which can be switched off) and one on the paper-out line (with selectable polarity). Either check sets a sticky error that withholds the transmit permit until the host clears it.

All three peripheral inputs are asynchronous and pass through a multi-flop synchronizer. The static configuration inputs stand in for board switches.

Top module: `prt_hs_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every output is driven low on that edge, including `tx_permit` and `err_flag`.
- R2: `line_dsr` is high from the first rising edge at which `rst` is low, and stays high until the next reset.
- R3: `line_rx_en` copies `host_rx_en` one edge later. `rx_byte_pass` is `rx_byte_valid` AND `host_rx_en`, registered one edge later, so a received byte is blocked while `host_rx_en` is low.
- R4: With `cfg_rdy_always`=1, `line_rdy` is 1 one edge later. With `cfg_rdy_always`=0, `line_rdy` is (`tx_valid` OR `tx_active`) registered one edge later.
- R5: `periph_er`, `periph_rdy` and `periph_po` pass through a SYNC_STAGES-flop synchronizer (default 2). With the default, a change on `periph_er` before rising edge k affects `tx_permit` from edge k+2 onward. While the synchronized equipment-ready is high and no error is pending, `tx_permit` is 1.
- R6: While the synchronized equipment-ready is low, each `tx_accept` pulse counts one byte. Once OVR_ALLOW bytes (default 2) have been counted, `tx_permit` drops on the same edge as the accept that completed the allowance and stays low. Out of reset the allowance starts used up, so no byte is permitted until equipment-ready has been seen high.
- R7: When the synchronized equipment-ready returns high, the byte count clears and the full allowance is available after the next fall.
- R8: With `cfg_rdy_check_en`=1, a low synchronized `periph_rdy` at an edge where `tx_active`=1 sets `err_flag` on that edge. An open line is to be pulled low on the board and is treated as low. Without `tx_active`, no error is raised.
- R9: With `cfg_rdy_check_en`=0, `periph_rdy` never causes an error.
- R10: A synchronized `periph_po` equal to `cfg_po_active_high` at an edge where `tx_active`=1 sets `err_flag`. Polarity: 1 means paper-out is signalled high, 0 means it is signalled low.
- R11: `err_flag` is sticky. It clears only on an edge with `err_clr`=1 and no new error condition; a new error wins over a clear in the same cycle. While `err_flag` is 1, `tx_permit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rdy_always | input | 1 | Static: 1 = ready line permanently high, 0 = ready follows transmit activity |
| cfg_rdy_check_en | input | 1 | Static: 1 = check peripheral ready line during transmit |
| cfg_po_active_high | input | 1 | Static: level of paper-out that signals an error |
| host_rx_en | input | 1 | Host enable for the receive direction |
| err_clr | input | 1 | Host write clearing the sticky error |
| tx_valid | input | 1 | Transmit path holds a byte to send |
| tx_accept | input | 1 | One-cycle pulse: transmit path took a byte |
| tx_active | input | 1 | A byte is being shifted out |
| rx_byte_valid | input | 1 | Receiver has a byte from the peripheral |
| periph_er | input | 1 | Peripheral equipment-ready, asynchronous |
| periph_rdy | input | 1 | Peripheral ready, asynchronous, open treated as low |
| periph_po | input | 1 | Peripheral paper-out, asynchronous |
| line_dsr | output | 1 | Data-set-ready to peripheral |
| line_rdy | output | 1 | Ready line to peripheral |
| line_rx_en | output | 1 | Receive-enabled line to peripheral |
| rx_byte_pass | output | 1 | Received byte forwarded to host |
| tx_permit | output | 1 | Transmit path may hand over a byte |
| err_flag | output | 1 | Sticky transmit-time error |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and an overrun allowance of two bytes. With these values the three-edge latency from an equipment-ready change to `tx_permit` can be seen directly. The bench also fills and exhausts the allowance with a continuously offered byte stream, and triggers each error source alone, together with a clear, and with its check switched off. A behavioural model sets the expected value of every output on every clock, so bytes accepted in the latency window and the sticky error's hold on the permit are checked exactly.

// File: rtl/prt_hs_pkg.sv
package prt_hs_pkg;
  localparam int N_LINES = 3;
  localparam int LN_ER   = 0;
  localparam int LN_RDY  = 1;
  localparam int LN_PO   = 2;
endpackage

// File: rtl/prt_hs_sync.sv
module prt_hs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prt_hs_err.sv
module prt_hs_err (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic rdy_ok,
  input  logic po_lvl,
  input  logic cfg_rdy_check_en,
  input  logic cfg_po_active_high,
  input  logic err_clr,
  output logic err_next,
  output logic err_q
);
  logic rdy_fault, po_fault, set_now;

  always_comb begin
    rdy_fault = cfg_rdy_check_en && !rdy_ok;
    po_fault  = (po_lvl == cfg_po_active_high);
    set_now   = tx_active && (rdy_fault || po_fault);
    err_next  = set_now || (err_q && !err_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_next;
  end
endmodule

// File: rtl/prt_hs_flow.sv
module prt_hs_flow #(
  parameter int OVR_ALLOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic er_ok,
  input  logic tx_accept,
  input  logic err_next,
  output logic tx_permit
);
  localparam int CW = $clog2(OVR_ALLOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OVR_ALLOW);

  logic [CW-1:0] sent_q, sent_n;

  always_comb begin
    sent_n = sent_q;
    if (er_ok)
      sent_n = '0;
    else if (tx_accept && (sent_q < LIMIT))
      sent_n = sent_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q    <= LIMIT;
      tx_permit <= 1'b0;
    end else begin
      sent_q    <= sent_n;
      tx_permit <= !err_next && (er_ok || (sent_n < LIMIT));
    end
  end
endmodule

// File: rtl/prt_hs_lines.sv
module prt_hs_lines (
  input  logic clk,
  input  logic rst,
  input  logic cfg_rdy_always,
  input  logic host_rx_en,
  input  logic tx_valid,
  input  logic tx_active,
  input  logic rx_byte_valid,
  output logic line_dsr,
  output logic line_rdy,
  output logic line_rx_en,
  output logic rx_byte_pass
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_dsr     <= 1'b0;
      line_rdy     <= 1'b0;
      line_rx_en   <= 1'b0;
      rx_byte_pass <= 1'b0;
    end else begin
      line_dsr     <= 1'b1;
      line_rdy     <= cfg_rdy_always || tx_valid || tx_active;
      line_rx_en   <= host_rx_en;
      rx_byte_pass <= rx_byte_valid && host_rx_en;
    end
  end
endmodule

// File: rtl/prt_hs_ctrl.sv
module prt_hs_ctrl
  import prt_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OVR_ALLOW   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_rdy_always,
  input  logic cfg_rdy_check_en,
  input  logic cfg_po_active_high,
  input  logic host_rx_en,
  input  logic err_clr,
  input  logic tx_valid,
  input  logic tx_accept,
  input  logic tx_active,
  input  logic rx_byte_valid,
  input  logic periph_er,
  input  logic periph_rdy,
  input  logic periph_po,
  output logic line_dsr,
  output logic line_rdy,
  output logic line_rx_en,
  output logic rx_byte_pass,
  output logic tx_permit,
  output logic err_flag
);
  logic [N_LINES-1:0] raw_lines, sync_lines;
  logic err_next;

  always_comb begin
    raw_lines         = '0;
    raw_lines[LN_ER]  = periph_er;
    raw_lines[LN_RDY] = periph_rdy;
    raw_lines[LN_PO]  = periph_po;
  end

  prt_hs_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_lines), .q(sync_lines)
  );

  prt_hs_err u_err (
    .clk(clk), .rst(rst),
    .tx_active(tx_active),
    .rdy_ok(sync_lines[LN_RDY]),
    .po_lvl(sync_lines[LN_PO]),
    .cfg_rdy_check_en(cfg_rdy_check_en),
    .cfg_po_active_high(cfg_po_active_high),
    .err_clr(err_clr),
    .err_next(err_next),
    .err_q(err_flag)
  );

  prt_hs_flow #(.OVR_ALLOW(OVR_ALLOW)) u_flow (
    .clk(clk), .rst(rst),
    .er_ok(sync_lines[LN_ER]),
    .tx_accept(tx_accept),
    .err_next(err_next),
    .tx_permit(tx_permit)
  );

  prt_hs_lines u_lines (
    .clk(clk), .rst(rst),
    .cfg_rdy_always(cfg_rdy_always),
    .host_rx_en(host_rx_en),
    .tx_valid(tx_valid),
    .tx_active(tx_active),
    .rx_byte_valid(rx_byte_valid),
    .line_dsr(line_dsr),
    .line_rdy(line_rdy),
    .line_rx_en(line_rx_en),
    .rx_byte_pass(rx_byte_pass)
  );
endmodule

// File: rtl/prt_hs_ctrl_chk.sv
module prt_hs_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cfg_rdy_always,
  input logic host_rx_en,
  input logic err_clr,
  input logic tx_active,
  input logic line_dsr,
  input logic line_rdy,
  input logic rx_byte_pass,
  input logic tx_permit,
  input logic err_flag
);
  AST_DSR_UP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> line_dsr);                                        // R2
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !host_rx_en |=> !rx_byte_pass);                            // R3
  AST_RDY_FORCED: assert property (@(posedge clk) disable iff (rst)
    cfg_rdy_always |=> line_rdy);                              // R4
  AST_NO_IDLE_ERR: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && !err_flag) |=> !err_flag);                  // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);                      // R11
  AST_ERR_NO_PERMIT: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !tx_permit);                                  // R11
endmodule

bind prt_hs_ctrl prt_hs_ctrl_chk chk_i (.*);

// File: tb/prt_hs_ctrl_tb_top.sv
module prt_hs_ctrl_tb_top;
  localparam int ALLOW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rdy_always = 1'b0, cfg_rdy_check_en = 1'b1, cfg_po_active_high = 1'b1;
  logic host_rx_en = 1'b0, err_clr = 1'b0;
  logic tx_valid = 1'b0, tx_accept = 1'b0, tx_active = 1'b0, rx_byte_valid = 1'b0;
  logic periph_er = 1'b0, periph_rdy = 1'b1, periph_po = 1'b0;
  logic line_dsr, line_rdy, line_rx_en, rx_byte_pass, tx_permit, err_flag;

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit live = 1'b0;

  always #4 clk = ~clk;

  prt_hs_ctrl #(.SYNC_STAGES(2), .OVR_ALLOW(ALLOW)) dut_i (.*);

  // behavioural reference
  int m_er1, m_er2, m_rd1, m_rd2, m_po1, m_po2, m_cnt;
  bit m_err, m_perm, m_dsr, m_rdy, m_rxen, m_rxp;

  always @(posedge clk) begin
    if (rst) begin
      m_er1 = 0; m_er2 = 0; m_rd1 = 0; m_rd2 = 0; m_po1 = 0; m_po2 = 0;
      m_cnt = ALLOW; m_err = 0; m_perm = 0;
      m_dsr = 0; m_rdy = 0; m_rxen = 0; m_rxp = 0;
    end else begin
      bit fault;
      if (m_er2 != 0) m_cnt = 0;
      else if (tx_accept && m_cnt < ALLOW) m_cnt = m_cnt + 1;
      fault = tx_active && ((cfg_rdy_check_en && m_rd2 == 0) ||
                            (m_po2 == int'(cfg_po_active_high)));
      m_err  = fault || (m_err && !err_clr);
      m_perm = !m_err && (m_er2 != 0 || m_cnt < ALLOW);
      m_dsr  = 1;
      m_rdy  = cfg_rdy_always || tx_valid || tx_active;
      m_rxen = host_rx_en;
      m_rxp  = rx_byte_valid && host_rx_en;
      m_er2 = m_er1; m_er1 = int'(periph_er);
      m_rd2 = m_rd1; m_rd1 = int'(periph_rdy);
      m_po2 = m_po1; m_po1 = int'(periph_po);
    end
    live = 1'b1;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R2", "line_dsr", line_dsr, m_dsr);
    chk("R3", "line_rx_en", line_rx_en, m_rxen);
    chk("R3", "rx_byte_pass", rx_byte_pass, m_rxp);
    chk("R4", "line_rdy", line_rdy, m_rdy);
    chk(tag, "tx_permit", tx_permit, m_perm);
    chk(tag, "err_flag", err_flag, m_err);
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_accept = tx_valid && tx_permit;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    tag = "R1";
    chk("R1", "reset tx_permit", tx_permit, 1'b0);
    chk("R1", "reset err_flag", err_flag, 1'b0);
    chk("R1", "reset line_dsr", line_dsr, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R2", "dsr after reset", line_dsr, 1'b1);
    tag = "R6";
    chk("R6", "no permit before ER seen", tx_permit, 1'b0);

    // receive gating
    rx_byte_valid = 1'b1; step(2);
    host_rx_en = 1'b1; step(3);
    chk("R3", "byte passes when enabled", rx_byte_pass, 1'b1);
    host_rx_en = 1'b0; step(2);
    chk("R3", "byte blocked when disabled", rx_byte_pass, 1'b0);
    rx_byte_valid = 1'b0;

    // ready line modes
    tx_valid = 1'b1; step(2); tx_valid = 1'b0; step(2);
    chk("R4", "ready follows activity", line_rdy, 1'b0);
    cfg_rdy_always = 1'b1; step(2);
    chk("R4", "ready forced", line_rdy, 1'b1);
    cfg_rdy_always = 1'b0;

    // flow control
    tag = "R5";
    periph_er = 1'b1; step(4);
    chk("R5", "permit with ER high", tx_permit, 1'b1);
    tx_valid = 1'b1; step(6);
    tag = "R6";
    periph_er = 1'b0; step(12);
    chk("R6", "permit low after allowance", tx_permit, 1'b0);
    tx_valid = 1'b0; step(2);
    tag = "R7";
    periph_er = 1'b1; step(4);
    chk("R7", "permit restored", tx_permit, 1'b1);
    periph_er = 1'b0; step(4);
    tx_valid = 1'b1; step(1); tx_valid = 1'b0; step(3);
    chk("R7", "one byte of allowance left", tx_permit, 1'b1);
    periph_er = 1'b1; step(3);

    // ready check
    tag = "R8";
    periph_rdy = 1'b0; step(3);
    chk("R8", "no error while idle", err_flag, 1'b0);
    tx_active = 1'b1; step(1); tx_active = 1'b0; step(1);
    chk("R8", "ready low sets error", err_flag, 1'b1);
    tag = "R11";
    step(3);
    chk("R11", "error sticky", err_flag, 1'b1);
    chk("R11", "permit withheld", tx_permit, 1'b0);
    err_clr = 1'b1; step(1); err_clr = 1'b0; step(1);
    chk("R11", "error cleared", err_flag, 1'b0);

    tag = "R9";
    cfg_rdy_check_en = 1'b0;
    tx_active = 1'b1; step(4); tx_active = 1'b0; step(1);
    chk("R9", "ready check disabled", err_flag, 1'b0);
    periph_rdy = 1'b1; cfg_rdy_check_en = 1'b1; step(3);

    // paper-out polarity
    tag = "R10";
    periph_po = 1'b1; step(3);
    tx_active = 1'b1; step(1); tx_active = 1'b0; step(1);
    chk("R10", "po high errors when active-high", err_flag, 1'b1);
    err_clr = 1'b1; step(1); err_clr = 1'b0;
    cfg_po_active_high = 1'b0;
    tx_active = 1'b1; step(2); tx_active = 1'b0; step(1);
    chk("R10", "po high fine when active-low", err_flag, 1'b0);
    periph_po = 1'b0; step(3);
    tx_active = 1'b1; step(1); tx_active = 1'b0; step(1);
    chk("R10", "po low errors when active-low", err_flag, 1'b1);

    // set wins over clear
    tag = "R11";
    err_clr = 1'b1; tx_active = 1'b1; step(1);
    err_clr = 1'b0; tx_active = 1'b0; step(1);
    chk("R11", "set beats clear", err_flag, 1'b1);
    periph_po = 1'b1; err_clr = 1'b1; step(4); err_clr = 1'b0; step(2);
    chk("R11", "cleared after condition gone", err_flag, 1'b0);

    summary();
  end
endmodule